// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block sits between a processor read port and a slower backing memory and serves word reads from a 16 KB direct-mapped store. Each 32-bit byte address is cut into an unsigned tag, a line index and a byte offset. The indexed line's valid flag and stored tag decide the outcome. On a hit the addressed word comes straight back. On a miss the whole four-word line is fetched from memory and installed with its tag. The requested word is returned once the refill has landed.

Every response carries a two-bit outcome code. The code tells apart a hit, a miss into an empty line and a miss that throws out a valid line of another tag. The processor side accepts one request at a time with a valid/ready handshake. The memory side issues one line-aligned read and waits any number of cycles for a 128-bit line. Whatever path a read takes, the returned value equals the memory contents at that address.

Top module: `dm_rdcache`

## Requirements
- R1: After reset every line is empty, so the first access to any line reports the cold-miss code 01. Right after reset, req_ready is 1, resp_valid is 0 and mem_req_valid is 0.
- R2: The address fields are fixed. The tag is bits [31:14] and the line index is bits [13:4]. The word within the line is bits [3:2]. Bits [1:0] have no effect on the outcome or the returned data.
- R3: An access whose line is valid and holds an equal tag reports code 00. Its response appears in the cycle after acceptance, and no memory request is raised.
- R4: An access to an invalid line reports code 01. It raises exactly one memory request whose address is the request address with bits [3:0] cleared, and it installs the line so that a later access with the same tag and index hits.
- R5: An access to a valid line holding a different tag reports code 10. The new line and tag replace the old ones, so a later access with the old tag misses with code 10.
- R6: resp_data always equals the memory word at the request address with bits [1:0] cleared. In the memory line response, word k (address bits [3:2] = k) occupies bits [32k+31:32k].
- R7: On a miss, req_ready stays low from acceptance until the response. The response appears in the cycle after the one in which mem_resp_valid is sampled high.
- R8: mem_req_valid and mem_req_addr hold steady until mem_req_ready is seen high. At most one memory request is outstanding at a time.
- R9: resp_valid is a one-cycle pulse for each accepted request. A new request may be accepted in the same cycle as a response is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Processor read request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | 32 | Byte address of the read |
| resp_valid | output | 1 | Response pulse |
| resp_data | output | 32 | Returned word |
| resp_code | output | 2 | 00 hit, 01 cold miss, 10 miss with replacement |
| mem_req_valid | output | 1 | Line fetch request to memory |
| mem_req_ready | input | 1 | Memory accepts the fetch request |
| mem_req_addr | output | 32 | Line-aligned fetch address |
| mem_resp_valid | input | 1 | Line data from memory present |
| mem_resp_line | input | 128 | Fetched line, word k in bits [32k+31:32k] |

## Verification
A response, whether a hit or the end of a refill, can be delivered in the same cycle that the next request is accepted. The bench provokes this by raising the next request in the very cycle a response is expected, so it often lands on the line that was just refilled or just evicted. A behavioural model keeps its own per-index tag and valid arrays, updated at each acceptance. The model predicts both the outcome code and the word, and each cycle the bench compares them with the ports. Memory handshake stalls and refill latency are varied so that the refill ending and the next acceptance fall on different relative cycles.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [1:0] {
    OUT_HIT   = 2'b00,
    OUT_COLD  = 2'b01,
    OUT_EVICT = 2'b10
  } outcome_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ASK  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/dmc_tagstore.sv
module dmc_tagstore #(
  parameter int LINES = 1024,
  parameter int IDX_W = 10,
  parameter int TAG_W = 18
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  input  logic             fill_we,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [TAG_W-1:0] fill_tag,
  output logic             line_valid,
  output logic             hit
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tags [LINES];

  always_ff @(posedge clk) begin
    if (rst) valid_q <= '0;
    else if (fill_we) valid_q[fill_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (fill_we) tags[fill_idx] <= fill_tag;
  end

  assign line_valid = valid_q[look_idx];
  assign hit        = valid_q[look_idx] && (tags[look_idx] == look_tag);

  // R1
  empty_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !line_valid);
endmodule

// File: rtl/dmc_linestore.sv
module dmc_linestore #(
  parameter int LINES  = 1024,
  parameter int IDX_W  = 10,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              we,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] mem [LINES];

  always_ff @(posedge clk) begin
    if (we) mem[wr_idx] <= wr_line;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_line <= mem[rd_idx];
  end
endmodule

// File: rtl/dmc_ctrl.sv
module dmc_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int OFS_W  = 4,
  parameter int SEL_W  = 2,
  parameter int LINE_W = 128,
  localparam int LA_W  = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [LA_W-1:0]   req_la,
  input  logic [SEL_W-1:0]  req_sel,
  input  logic              hit,
  input  logic              line_valid,
  input  logic              mem_req_ready,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_line,
  output logic              req_ready,
  output logic              accept,
  output logic              mem_req_valid,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic              fill_we,
  output logic [LA_W-1:0]   held_la,
  output logic [SEL_W-1:0]  sel_q,
  output logic              resp_valid,
  output logic [1:0]        resp_code,
  output logic              src_fill,
  output logic [WORD_W-1:0] fill_word
);
  state_e   state_q;
  outcome_e miss_code_q;

  assign req_ready    = (state_q == ST_IDLE);
  assign accept       = req_ready && req_valid;
  assign fill_we      = (state_q == ST_WAIT) && mem_resp_valid;
  assign mem_req_addr = {held_la, {OFS_W{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      miss_code_q   <= OUT_COLD;
      mem_req_valid <= 1'b0;
      resp_valid    <= 1'b0;
      resp_code     <= OUT_HIT;
      src_fill      <= 1'b0;
      held_la       <= '0;
      sel_q         <= '0;
      fill_word     <= '0;
    end else begin
      resp_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_valid) begin
          held_la <= req_la;
          sel_q   <= req_sel;
          if (hit) begin
            resp_valid <= 1'b1;
            resp_code  <= OUT_HIT;
            src_fill   <= 1'b0;
          end else begin
            miss_code_q   <= line_valid ? OUT_EVICT : OUT_COLD;
            mem_req_valid <= 1'b1;
            state_q       <= ST_ASK;
          end
        end
        ST_ASK: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state_q       <= ST_WAIT;
        end
        ST_WAIT: if (mem_resp_valid) begin
          resp_valid <= 1'b1;
          resp_code  <= miss_code_q;
          src_fill   <= 1'b1;
          fill_word  <= mem_resp_line[sel_q*WORD_W +: WORD_W];
          state_q    <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R8
  fetch_hold_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R7
  refill_reply_chk: assert property (@(posedge clk) disable iff (rst)
    !req_ready && !mem_req_valid && mem_resp_valid |=> resp_valid && req_ready);
endmodule

// File: rtl/dm_rdcache.sv
module dm_rdcache #(
  parameter int ADDR_W     = 32,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int LINES      = 1024,
  localparam int LINE_W    = LINE_WORDS * WORD_W,
  localparam int OFS_W     = $clog2(LINE_W / 8),
  localparam int WB_W      = $clog2(WORD_W / 8),
  localparam int SEL_W     = $clog2(LINE_WORDS),
  localparam int IDX_W     = $clog2(LINES),
  localparam int TAG_W     = ADDR_W - IDX_W - OFS_W,
  localparam int LA_W      = ADDR_W - OFS_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              resp_valid,
  output logic [WORD_W-1:0] resp_data,
  output logic [1:0]        resp_code,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_resp_valid,
  input  logic [LINE_W-1:0] mem_resp_line
);
  logic [IDX_W-1:0]  req_idx, held_idx;
  logic [TAG_W-1:0]  req_tag, held_tag;
  logic [SEL_W-1:0]  req_sel, sel_q;
  logic [LA_W-1:0]   req_la, held_la;
  logic              hit, line_valid, accept, fill_we, src_fill;
  logic [LINE_W-1:0] rd_line;
  logic [WORD_W-1:0] fill_word;
  logic [WORD_W-1:0] ram_words [LINE_WORDS];

  assign req_idx  = req_addr[OFS_W +: IDX_W];
  assign req_tag  = req_addr[ADDR_W-1 -: TAG_W];
  assign req_sel  = req_addr[WB_W +: SEL_W];
  assign req_la   = req_addr[ADDR_W-1 -: LA_W];
  assign held_idx = held_la[IDX_W-1:0];
  assign held_tag = held_la[LA_W-1 -: TAG_W];

  dmc_tagstore #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .look_idx(req_idx), .look_tag(req_tag),
    .fill_we(fill_we), .fill_idx(held_idx), .fill_tag(held_tag),
    .line_valid(line_valid), .hit(hit)
  );

  dmc_linestore #(.LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_lines (
    .clk(clk),
    .rd_en(accept), .rd_idx(req_idx), .rd_line(rd_line),
    .we(fill_we), .wr_idx(held_idx), .wr_line(mem_resp_line)
  );

  dmc_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OFS_W(OFS_W), .SEL_W(SEL_W),
             .LINE_W(LINE_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_la(req_la), .req_sel(req_sel),
    .hit(hit), .line_valid(line_valid),
    .mem_req_ready(mem_req_ready), .mem_resp_valid(mem_resp_valid),
    .mem_resp_line(mem_resp_line),
    .req_ready(req_ready), .accept(accept),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .fill_we(fill_we), .held_la(held_la), .sel_q(sel_q),
    .resp_valid(resp_valid), .resp_code(resp_code),
    .src_fill(src_fill), .fill_word(fill_word)
  );

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_word
    assign ram_words[g] = rd_line[g*WORD_W +: WORD_W];
  end

  assign resp_data = src_fill ? fill_word : ram_words[sel_q];

  // R3
  hit_fast_chk: assert property (@(posedge clk) disable iff (rst)
    accept && hit |=> resp_valid && resp_code == 2'b00 && !mem_req_valid);

  // R9
  reply_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> req_ready);
endmodule

// File: tb/dm_rdcache_tb.sv
`timescale 1ns/1ps
module dm_rdcache_tb;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [31:0]  req_addr = '0;
  logic         resp_valid;
  logic [31:0]  resp_data;
  logic [1:0]   resp_code;
  logic         mem_req_valid;
  logic         mem_req_ready = 1'b0;
  logic [31:0]  mem_req_addr;
  logic         mem_resp_valid = 1'b0;
  logic [127:0] mem_resp_line = '0;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // behavioural model state
  bit          m_valid [1024];
  int unsigned m_tag   [1024];
  logic [1:0]  exp_code;
  logic [31:0] exp_data;
  logic [31:0] cur_addr;
  int unsigned seed = 32'h1234_5678;

  always #5 clk = ~clk;

  dm_rdcache u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
    .resp_code(resp_code), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_resp_valid(mem_resp_valid), .mem_resp_line(mem_resp_line)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [31:0] w;
    w = {a[31:2], 2'b00};
    return (w * 32'h0019_660D) ^ 32'h3C6E_F35F;
  endfunction

  function automatic int unsigned rnd();
    seed = seed * 32'd1103515245 + 32'd12345;
    return seed >> 8;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  // memory responder: acts exactly at the falling edge
  initial begin : mem_model
    bit          armed = 0;
    bit          pending = 0;
    int unsigned lat = 0;
    logic [31:0] cap = '0;
    logic [31:0] line_a = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        armed = 0; pending = 0;
        mem_resp_valid = 1'b0;
        mem_req_ready = 1'b0;
      end else begin
        if (armed) begin
          pending = 1; lat = rnd() % 4; line_a = cap;
        end
        armed = 0;
        mem_resp_valid = 1'b0;
        if (pending) begin
          if (lat == 0) begin
            for (int k = 0; k < 4; k++)
              mem_resp_line[k*32 +: 32] = mem_word(line_a + 32'(4 * k));
            mem_resp_valid = 1'b1;
            pending = 0;
          end else lat--;
        end
        mem_req_ready = (rnd() % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
          armed = 1; cap = mem_req_addr;
        end
      end
    end
  end

  // drive a request at the current (post-falling-edge) time; returns after the accepting edge
  task automatic issue(input logic [31:0] a);
    int unsigned idx, tg;
    req_valid = 1'b1;
    req_addr  = a;
    while (!req_ready) tick();
    idx = a[13:4];
    tg  = a[31:14];
    if (m_valid[idx] && m_tag[idx] == tg) exp_code = 2'b00;
    else if (!m_valid[idx])               exp_code = 2'b01;
    else                                  exp_code = 2'b10;
    m_valid[idx] = 1;
    m_tag[idx]   = tg;
    exp_data = mem_word(a);
    cur_addr = a;
    @(posedge clk);
  endtask

  task automatic finish(input string req);
    bit prev_fill;
    bit seen_req;
    int guard;
    tick();
    req_valid = 1'b0;
    if (exp_code == 2'b00) begin
      chk(resp_valid === 1'b1, "R3", {req, " hit response in next cycle"}, 32'(resp_valid), 1);
      chk(resp_code === 2'b00, "R3", {req, " hit code"}, 32'(resp_code), 0);
      chk(mem_req_valid === 1'b0, "R3", {req, " no fetch on hit"}, 32'(mem_req_valid), 0);
      chk(resp_data === exp_data, "R6", {req, " hit data"}, resp_data, exp_data);
    end else begin
      prev_fill = 0;
      seen_req  = 0;
      guard     = 0;
      while (1) begin
        if (prev_fill) begin
          chk(resp_valid === 1'b1, "R7", {req, " refill response timing"}, 32'(resp_valid), 1);
          chk(resp_code === exp_code, exp_code == 2'b01 ? "R4" : "R5",
              {req, " miss code"}, 32'(resp_code), 32'(exp_code));
          chk(resp_data === exp_data, "R6", {req, " refill data"}, resp_data, exp_data);
          chk(req_ready === 1'b1, "R9", {req, " ready with response"}, 32'(req_ready), 1);
          break;
        end
        chk(resp_valid === 1'b0 && req_ready === 1'b0, "R7",
            {req, " quiet and stalled during refill"}, {30'd0, resp_valid, req_ready}, 0);
        if (mem_req_valid && !seen_req) begin
          seen_req = 1;
          chk(mem_req_addr === {cur_addr[31:4], 4'h0}, "R4", {req, " fetch address"},
              mem_req_addr, {cur_addr[31:4], 4'h0});
        end
        prev_fill = mem_resp_valid;
        guard++;
        if (guard > 60) begin
          chk(0, "R7", {req, " refill never answered"}, 0, 1);
          break;
        end
        tick();
      end
      chk(seen_req, "R8", {req, " one fetch request seen"}, 32'(seen_req), 1);
    end
  endtask

  task automatic access(input logic [31:0] a, input string req);
    issue(a);
    finish(req);
  endtask

  task automatic expect_code(input logic [1:0] c, input string req);
    chk(exp_code === c, req, "model outcome agrees with scenario", 32'(exp_code), 32'(c));
  endtask

  task automatic do_reset();
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (3) tick();
    for (int i = 0; i < 1024; i++) begin m_valid[i] = 0; m_tag[i] = 0; end
    rst = 1'b0;
    tick();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    // R1 reset state at the ports
    chk(req_ready === 1'b1, "R1", "ready after reset", 32'(req_ready), 1);
    chk(resp_valid === 1'b0, "R1", "no response after reset", 32'(resp_valid), 0);
    chk(mem_req_valid === 1'b0, "R1", "no fetch after reset", 32'(mem_req_valid), 0);

    // walkthrough of a small access pattern
    access(32'h0000_0014, "R1 first touch"); expect_code(2'b01, "R1");
    access(32'h0000_001C, "R3 same line");   expect_code(2'b00, "R3");
    access(32'h0000_0017, "R2 low bits");    expect_code(2'b00, "R2");
    chk(resp_data === mem_word(32'h14), "R2", "bits [1:0] ignored", resp_data, mem_word(32'h14));
    access(32'h0000_0034, "R4 other line");  expect_code(2'b01, "R4");
    access(32'h0000_8014, "R5 conflict");    expect_code(2'b10, "R5");
    access(32'h0000_0030, "R3 kept line");   expect_code(2'b00, "R3");
    access(32'h0000_001C, "R5 old tag back");expect_code(2'b10, "R5");

    // index boundaries
    access(32'h0000_3FF8, "R2 top index");   expect_code(2'b01, "R2");
    access(32'h0000_7FF4, "R5 top index");   expect_code(2'b10, "R5");
    access(32'h0000_3FFC, "R5 top back");    expect_code(2'b10, "R5");
    access(32'h0000_000C, "R2 index zero");  expect_code(2'b01, "R2");
    access(32'h0000_0008, "R9 back-to-back");expect_code(2'b00, "R9");

    // reset clears every line again
    do_reset();
    access(32'h0000_001C, "R1 after reset"); expect_code(2'b01, "R1");

    // mixed sweep: next request raised in the response cycle, sometimes after a gap
    for (int n = 0; n < 250; n++) begin
      int unsigned idxs [8] = '{0, 1, 2, 3, 5, 1021, 1022, 1023};
      logic [31:0] a;
      a = (32'(rnd() % 3) << 14) | (32'(idxs[rnd() % 8]) << 4) | 32'(rnd() % 16);
      if (rnd() % 4 == 0) tick();
      access(a, "R9 sweep");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule